// File: doc/BRIEF.md
# Out-of-band burst sequence detector

This block recognises the two serial-link out-of-band wake-up sequences on a receiver lane. A squelch comparator outside the block reports whether signal energy is on the line. The block passes that level through a two-flop synchronizer. It samples the synchronized level on a clock enable, which is the core clock divided by a fixed ratio. It then measures every burst (squelch high) and every quiet interval (squelch low) as a count of samples.

Each burst is judged against one width window. Each quiet interval is sorted by width alone into a short (wake) gap, a long (init) gap or an invalid gap. Once four valid gap-then-burst pairs of one kind have been seen in a row, the block raises a one-cycle COMWAKE or COMINIT detect pulse. The link state machine uses these pulses to start the speed negotiation.

All widths are parameters counted in sample periods. The defaults assume a sample period of about 13.3 ns. Under that assumption the burst window is 5 to 13 samples, a wake gap is 5 to 13 samples and an init gap is 14 to 39 samples.

Top module: `oob_burst_detect`

## Requirements
- R1: Squelch held at one level for N×DIV consecutive clock cycles is measured as a segment of exactly N samples. The sampling path has a two-flop synchronizer and a divide-by-DIV enable.
- R2: A burst is valid when its width is from BURST_MIN to BURST_MAX samples inclusive. Widths between the accept limits and the reject limits count as valid. With the defaults (5 to 13), bursts of 5 and 13 samples are valid and bursts of 4 and 14 samples are not.
- R3: A gap of WAKE_MIN to WAKE_MAX samples (default 5 to 13) is a wake gap. A gap of INIT_MIN to INIT_MAX samples (default 14 to 39) is an init gap. Any other width, for example 4 or 40, is invalid.
- R4: A valid burst arms the detector. Each valid gap followed by a valid burst forms one pair, counted when that burst ends. When the fourth consecutive pair of one kind is counted, comwake_det (wake gaps) or cominit_det (init gaps) is high for exactly one clock cycle. With these rules, five valid bursts separated by four gaps of one kind give one pulse.
- R5: An invalid burst or an invalid gap clears the pair count and disarms the detector. No pulse follows until a valid burst has re-armed it and four further pairs have been counted.
- R6: A valid gap whose kind differs from the kind of the pairs counted so far restarts the count. The pair it forms becomes the first pair of a run of the new kind.
- R7: The width counter saturates at 2^CNT_W−1 and never wraps. A quiet interval that reaches saturation clears the pair count and disarms the detector.
- R8: A synchronous reset clears the synchronizer, the divider, the counters and the run state, and both detect outputs are low while reset is held and on the cycle after.
- R9: The two detect outputs are never high together. After a pulse the pair count restarts from zero, and the burst that completed the run re-arms the detector, so nine bursts with eight gaps of one kind give two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| squelch_in | input | 1 | Asynchronous line-activity level, high while a burst is present |
| cominit_det | output | 1 | One-cycle pulse on a completed run of init-gap pairs |
| comwake_det | output | 1 | One-cycle pulse on a completed run of wake-gap pairs |

## Verification
The hardest state to reach from the pins is a run stopped partway through: three pairs counted, followed by a kind change, an out-of-window width one sample beyond a limit, a saturating quiet interval, or a reset. The stimulus holds the squelch level for whole multiples of the divide ratio, so every segment width is known exactly whatever the divider phase. Directed sequences place widths one sample inside and one sample outside each limit. Seeded random sequences mix valid and invalid widths of both kinds, and an event-level model in the bench predicts the pulse counts after each sequence is flushed.

// File: rtl/oob_pkg.sv
package oob_pkg;

    // Kind of a quiet interval, decided from its width alone.
    typedef enum logic [1:0] {
        GAP_NONE = 2'd0,
        GAP_WAKE = 2'd1,
        GAP_INIT = 2'd2
    } gap_kind_e;

endpackage

// File: rtl/oob_sync.sv
module oob_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/oob_sample_div.sv
module oob_sample_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_pass
            assign en = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_d, cnt_q;
            logic          wrap;

            always_comb begin
                wrap  = (cnt_q == CW'(DIV - 1));
                cnt_d = wrap ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_d;
            end

            assign en = wrap;
        end
    endgenerate
endmodule

// File: rtl/oob_seg_meas.sv
module oob_seg_meas #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             lvl,
    output logic             seg_end,
    output logic             seg_lvl,
    output logic [CNT_W-1:0] seg_len,
    output logic             idle_sat,
    output logic [CNT_W-1:0] seg_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } meas_t;

    meas_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        seg_end  = 1'b0;
        idle_sat = 1'b0;
        if (en) begin
            if (lvl != st_q.prev) begin
                seg_end  = 1'b1;
                st_d.prev = lvl;
                st_d.cnt  = CNT_W'(1);
            end else if (st_q.cnt != CMAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
                // Quiet interval reaches the ceiling on this sample.
                if (!st_q.prev && (st_q.cnt == CMAX - 1'b1)) idle_sat = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign seg_lvl = st_q.prev;
    assign seg_len = st_q.cnt;
    assign seg_cnt = st_q.cnt;
endmodule

// File: rtl/oob_seq.sv
module oob_seq
    import oob_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int BURST_MIN = 5,
    parameter int BURST_MAX = 13,
    parameter int WAKE_MIN  = 5,
    parameter int WAKE_MAX  = 13,
    parameter int INIT_MIN  = 14,
    parameter int INIT_MAX  = 39,
    parameter int RUN_LEN   = 4,
    localparam int RUN_W    = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_end,
    input  logic             seg_lvl,
    input  logic [CNT_W-1:0] seg_len,
    input  logic             idle_sat,
    output logic             init_pulse,
    output logic             wake_pulse,
    output logic [RUN_W-1:0] run_level
);
    typedef struct packed {
        logic             armed;
        logic             pend_v;
        gap_kind_e        pend_k;
        logic [RUN_W-1:0] run;
        gap_kind_e        run_k;
        logic             init_p;
        logic             wake_p;
    } seq_t;

    seq_t st_d, st_q;

    function automatic gap_kind_e classify(input logic [CNT_W-1:0] len);
        if (len >= CNT_W'(WAKE_MIN) && len <= CNT_W'(WAKE_MAX)) return GAP_WAKE;
        if (len >= CNT_W'(INIT_MIN) && len <= CNT_W'(INIT_MAX)) return GAP_INIT;
        return GAP_NONE;
    endfunction

    gap_kind_e gk;
    logic      burst_ok;

    always_comb begin
        gk       = classify(seg_len);
        burst_ok = (seg_len >= CNT_W'(BURST_MIN)) && (seg_len <= CNT_W'(BURST_MAX));
        st_d        = st_q;
        st_d.init_p = 1'b0;
        st_d.wake_p = 1'b0;
        if (idle_sat) begin
            st_d.armed  = 1'b0;
            st_d.pend_v = 1'b0;
            st_d.run    = '0;
        end else if (seg_end && !seg_lvl) begin
            // A quiet interval has just ended.
            if (st_q.armed) begin
                if (gk == GAP_NONE) begin
                    st_d.armed  = 1'b0;
                    st_d.pend_v = 1'b0;
                    st_d.run    = '0;
                end else begin
                    if (st_q.run != '0 && gk != st_q.run_k) st_d.run = '0;
                    st_d.pend_v = 1'b1;
                    st_d.pend_k = gk;
                end
            end
        end else if (seg_end && seg_lvl) begin
            // A burst has just ended.
            if (burst_ok) begin
                st_d.armed  = 1'b1;
                st_d.pend_v = 1'b0;
                if (st_q.pend_v) begin
                    st_d.run_k = st_q.pend_k;
                    if (st_q.run == RUN_W'(RUN_LEN - 1)) begin
                        st_d.run    = '0;
                        st_d.init_p = (st_q.pend_k == GAP_INIT);
                        st_d.wake_p = (st_q.pend_k == GAP_WAKE);
                    end else begin
                        st_d.run = st_q.run + 1'b1;
                    end
                end
            end else begin
                st_d.armed  = 1'b0;
                st_d.pend_v = 1'b0;
                st_d.run    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.pend_k <= GAP_NONE;
            st_q.run_k  <= GAP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_pulse = st_q.init_p;
    assign wake_pulse = st_q.wake_p;
    assign run_level  = st_q.run;
endmodule

// File: rtl/oob_burst_detect.sv
module oob_burst_detect #(
    parameter int DIV       = 2,
    parameter int CNT_W     = 6,
    parameter int BURST_MIN = 5,
    parameter int BURST_MAX = 13,
    parameter int WAKE_MIN  = 5,
    parameter int WAKE_MAX  = 13,
    parameter int INIT_MIN  = 14,
    parameter int INIT_MAX  = 39,
    parameter int RUN_LEN   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic squelch_in,
    output logic cominit_det,
    output logic comwake_det
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic             sq_sync;
    logic             sample_en;
    logic             seg_end;
    logic             seg_lvl;
    logic [CNT_W-1:0] seg_len;
    logic             idle_sat;
    logic [CNT_W-1:0] seg_cnt;
    logic [RUN_W-1:0] run_cnt;

    oob_sync #(.STAGES(2)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (squelch_in),
        .q   (sq_sync)
    );

    oob_sample_div #(.DIV(DIV)) div_i (
        .clk (clk),
        .rst (rst),
        .en  (sample_en)
    );

    oob_seg_meas #(.CNT_W(CNT_W)) meas_i (
        .clk      (clk),
        .rst      (rst),
        .en       (sample_en),
        .lvl      (sq_sync),
        .seg_end  (seg_end),
        .seg_lvl  (seg_lvl),
        .seg_len  (seg_len),
        .idle_sat (idle_sat),
        .seg_cnt  (seg_cnt)
    );

    oob_seq #(
        .CNT_W     (CNT_W),
        .BURST_MIN (BURST_MIN),
        .BURST_MAX (BURST_MAX),
        .WAKE_MIN  (WAKE_MIN),
        .WAKE_MAX  (WAKE_MAX),
        .INIT_MIN  (INIT_MIN),
        .INIT_MAX  (INIT_MAX),
        .RUN_LEN   (RUN_LEN)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .seg_end    (seg_end),
        .seg_lvl    (seg_lvl),
        .seg_len    (seg_len),
        .idle_sat   (idle_sat),
        .init_pulse (cominit_det),
        .wake_pulse (comwake_det),
        .run_level  (run_cnt)
    );
endmodule

// File: rtl/oob_burst_detect_chk.sv
module oob_burst_detect_chk #(
    parameter int CNT_W   = 6,
    parameter int RUN_LEN = 4,
    parameter int RUN_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             sample_en,
    input logic             seg_end,
    input logic [CNT_W-1:0] seg_cnt,
    input logic [RUN_W-1:0] run_cnt,
    input logic             cominit_det,
    input logic             comwake_det
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // R4: each detect pulse lasts one cycle
    a_r4_one_cycle_init: assert property (@(posedge clk) disable iff (rst)
        cominit_det |=> !cominit_det);
    a_r4_one_cycle_wake: assert property (@(posedge clk) disable iff (rst)
        comwake_det |=> !comwake_det);

    // R4: a pulse follows a sample that closed the last pair of a full run
    a_r4_on_sample: assert property (@(posedge clk) disable iff (rst)
        (cominit_det || comwake_det) |-> ($past(sample_en) && $past(seg_end)
                                          && $past(run_cnt) == RUN_W'(RUN_LEN - 1)));

    // R9: never both kinds at once
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cominit_det && comwake_det));

    // R7: the width counter holds at its ceiling until a boundary
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ($past(seg_cnt) == CMAX && !$past(seg_end)) |-> seg_cnt == CMAX);

    // R8: reset clears outputs and counters
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!cominit_det && !comwake_det && seg_cnt == '0 && run_cnt == '0));
endmodule

bind oob_burst_detect oob_burst_detect_chk #(
    .CNT_W   (CNT_W),
    .RUN_LEN (RUN_LEN),
    .RUN_W   (RUN_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sample_en   (sample_en),
    .seg_end     (seg_end),
    .seg_cnt     (seg_cnt),
    .run_cnt     (run_cnt),
    .cominit_det (cominit_det),
    .comwake_det (comwake_det)
);

// File: tb/oob_burst_detect_tb_top.sv
module oob_burst_detect_tb_top;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic squelch_in = 1'b0;
    logic cominit_det, comwake_det;

    int errors = 0;
    int checks = 0;
    int obs_init = 0, obs_wake = 0;
    int exp_init = 0, exp_wake = 0;

    // event-level model state
    bit m_armed = 0, m_pend = 0;
    int m_pend_k = 0, m_run = 0, m_run_k = 0;

    always #5 clk = ~clk;

    oob_burst_detect #(.DIV(DIV)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .squelch_in  (squelch_in),
        .cominit_det (cominit_det),
        .comwake_det (comwake_det)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cominit_det) obs_init++;
            if (comwake_det) obs_wake++;
        end
    end

    function automatic int gap_kind(input int n);
        if (n >= 5 && n <= 13) return 1;   // wake
        if (n >= 14 && n <= 39) return 2;  // init
        return 0;
    endfunction

    function automatic bit burst_ok(input int n);
        return (n >= 5 && n <= 13);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_armed = 0; m_pend = 0; m_run = 0;
    endtask

    task automatic burst(input int n);
        squelch_in = 1'b1;
        repeat (n * DIV) @(posedge clk);
        #1;
        if (burst_ok(n)) begin
            m_armed = 1;
            if (m_pend) begin
                m_run_k = m_pend_k;
                m_run++;
                if (m_run == 4) begin
                    m_run = 0;
                    if (m_pend_k == 2) exp_init++; else exp_wake++;
                end
            end
            m_pend = 0;
        end else model_clear();
    endtask

    task automatic gap(input int n);
        int k;
        squelch_in = 1'b0;
        repeat (n * DIV) @(posedge clk);
        #1;
        k = gap_kind(n);
        if (m_armed) begin
            if (k == 0) model_clear();
            else begin
                if (m_run != 0 && k != m_run_k) m_run = 0;
                m_pend = 1; m_pend_k = k;
            end
        end
    endtask

    task automatic flush_check(input string req);
        gap(70);
        check({req, " init count"}, obs_init, exp_init);
        check({req, " wake count"}, obs_wake, exp_wake);
    endtask

    task automatic train(input int nb, input int bw, input int gw);
        for (int i = 0; i < nb; i++) begin
            burst(bw);
            if (i != nb - 1) gap(gw);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nb, bw, gw, kind;
        void'($urandom(32'd24680));
        repeat (4) @(posedge clk);
        #1;
        // R8: outputs low during reset
        check("R8 reset init", int'(cominit_det), 0);
        check("R8 reset wake", int'(comwake_det), 0);
        rst = 1'b0;
        gap(10);

        // R4: five valid bursts with four wake gaps -> one wake pulse
        train(5, 8, 8);   flush_check("R4 wake run");
        // R4: init run
        train(5, 8, 24);  flush_check("R4 init run");
        // R1 R2 R3: accepted edges, bursts 5/13, wake gap 13, init gaps 14/39
        burst(5); gap(13); burst(13); gap(13); burst(5); gap(13); burst(13); gap(13); burst(5);
        flush_check("R1 R2 R3 wake edges");
        burst(13); gap(14); burst(5); gap(39); burst(13); gap(14); burst(5); gap(39); burst(13);
        flush_check("R2 R3 init edges");
        // R2 R5: burst of 4 or 14 mid-run breaks the run
        burst(8); gap(8); burst(8); gap(8); burst(4); gap(8); burst(8); gap(8); burst(8);
        flush_check("R2 R5 short burst");
        burst(8); gap(24); burst(14); gap(24); burst(8); gap(24); burst(8); gap(24); burst(8);
        flush_check("R2 R5 long burst");
        // R3 R5: gaps of 4 and 40 are invalid
        burst(8); gap(8); burst(8); gap(4); burst(8); gap(8); burst(8); gap(8); burst(8);
        flush_check("R3 R5 short gap");
        burst(8); gap(24); burst(8); gap(40); burst(8); gap(24); burst(8); gap(24); burst(8);
        flush_check("R3 R5 long gap");
        // R6: two wake pairs then four init pairs -> one init, no wake
        burst(8); gap(8); burst(8); gap(8); burst(8);
        gap(24); burst(8); gap(24); burst(8); gap(24); burst(8); gap(24); burst(8);
        flush_check("R6 kind switch");
        // R9: nine bursts, eight wake gaps -> two pulses
        train(9, 8, 8);   flush_check("R9 rearm");
        // R7: three pairs, saturating quiet interval, two more pairs
        train(4, 8, 8); gap(70); train(3, 8, 8);
        flush_check("R7 idle saturation");
        // R7: long burst saturates the counter and is rejected
        train(3, 8, 24); burst(80); gap(24); train(3, 8, 24);
        flush_check("R7 burst saturation");
        // R8: reset mid-run
        train(4, 8, 8); gap(8);
        rst = 1'b1; repeat (3) @(posedge clk); #1;
        check("R8 mid reset init", int'(cominit_det), 0);
        check("R8 mid reset wake", int'(comwake_det), 0);
        rst = 1'b0; model_clear();
        gap(10);
        train(2, 8, 8);
        flush_check("R8 run cleared");

        // R2 R3 R4 R5 R6: seeded random sequences
        for (int s = 0; s < 40; s++) begin
            nb = 2 + int'($urandom_range(6));
            kind = int'($urandom_range(1));
            for (int i = 0; i < nb; i++) begin
                bw = ($urandom_range(9) < 8) ? 5 + int'($urandom_range(8)) : 3 + int'($urandom_range(14));
                burst(bw);
                if (i != nb - 1) begin
                    if ($urandom_range(9) < 8)
                        gw = (kind == 0) ? 5 + int'($urandom_range(8)) : 14 + int'($urandom_range(25));
                    else
                        gw = 3 + int'($urandom_range(40));
                    gap(gw);
                end
            end
            flush_check("R4 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule